// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block controls the low-power state of a small single-issue microcontroller core. When the instruction decoder signals that a sleep instruction is executing, the controller either turns the request into a no-op, because an enabled interrupt is already pending, or it stops the core clock and marks the power-down status. While the core is asleep it watches three wake sources: an external reset request, a watchdog timeout, and any interrupt whose own enable and flag bits are both set. The global interrupt enable does not take part in the wake decision.

On wake-up the controller clears the watchdog and keeps the core clock off while an oscillator start-up counter runs. The count length depends on an oscillator-mode input. It then either requests a full core reset, or it re-enables the clock so that the instruction prefetched during sleep can execute. When that instruction retires, the controller raises a one-cycle vector request if the global enable is set. If the global enable is clear, the core carries on in-line. The controller also holds the timeout and power-down status bits that software reads to find the wake cause.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After a synchronous reset `core_clk_en`=1, `status_pd`=1 and `status_to`=1, and `wdt_clear`, `vector_req` and `core_reset` are 0.
- R2: A `sleep_exec` strobe in the awake state with no enabled interrupt pending drops `core_clk_en` to 0, clears `status_pd` and sets `status_to` on the next cycle.
- R3: If some bit i has `irq_en[i]`=1 and `irq_flag[i]`=1 when `sleep_exec` is seen, the sleep is a no-op whatever `gie` is. `core_clk_en` stays 1 and both status bits keep their values.
- R4: While asleep, an interrupt wakes the core only when some bit has both its enable and its flag set. A flag without its enable has no effect, and `gie` has no effect.
- R5: A watchdog wake clears `status_to`. An interrupt wake leaves `status_to` at 1.
- R6: Every wake, whatever its source, starts with a one-cycle `wdt_clear` pulse in the first start-up cycle.
- R7: `core_clk_en` stays 0 for XTAL_CYCLES cycles of start-up when `osc_rc`=0, and for RC_CYCLES cycles when `osc_rc`=1. The count starts with the `wdt_clear` cycle.
- R8: After a wake that is not a reset wake, `core_clk_en` returns to 1. The cycle after `prefetch_retire` is seen, `vector_req` is 1 for exactly one cycle if `gie`=1, and stays 0 if `gie`=0.
- R9: An external reset wake ends its start-up with a one-cycle `core_reset` pulse and no `vector_req`. `status_pd` stays 0 and `status_to` stays 1. When sources coincide, the priority is external reset, then watchdog, then interrupt.
- R10: `sleep_exec` while asleep, and `ext_reset_req` or `wdt_timeout` while awake, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sleep_exec | input | 1 | Sleep instruction is executing |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| irq_flag | input | N_IRQ | Per-source interrupt flags |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog timeout |
| ext_reset_req | input | 1 | External reset request |
| osc_rc | input | 1 | 1 selects the short RC start-up, 0 selects the crystal start-up |
| prefetch_retire | input | 1 | Prefetched instruction has retired |
| core_clk_en | output | 1 | Core clock enable |
| wdt_clear | output | 1 | Watchdog clear pulse |
| vector_req | output | 1 | Branch to interrupt vector 0x0004 |
| core_reset | output | 1 | Full core reset pulse |
| status_pd | output | 1 | Power-down status bit |
| status_to | output | 1 | Timeout status bit |

## Verification
Every output is registered, so the effect of a sleep strobe, a wake stimulus or a retire strobe shows one clock edge after it. The bench drives inputs on the falling edge and samples on the next falling edge. The start-up length is measured by counting the samples in which `core_clk_en` is low, beginning with the sample that shows `wdt_clear`, and that count must equal the selected cycle count exactly. `vector_req` and `core_reset` are checked in the sample that follows their trigger, and checked again one sample later to confirm that each pulse lasts a single cycle.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ASLEEP  = 2'd1,
    ST_STARTUP = 2'd2,
    ST_RESUME  = 2'd3
  } slp_state_t;

  typedef enum logic [1:0] {
    WK_IRQ = 2'd0,
    WK_WDT = 2'd1,
    WK_RST = 2'd2
  } wake_src_t;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_IRQ-1:0] irq_flag,
  output logic             pending
);
  logic [N_IRQ-1:0] armed;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign armed[i] = irq_en[i] & irq_flag[i];
  end

  assign pending = |armed;
endmodule

// File: rtl/startup_timer.sv
module startup_timer #(
  parameter int XTAL_CYCLES = 1024,
  parameter int RC_CYCLES   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic osc_rc,
  input  logic run,
  output logic done
);
  localparam int MAXC = (XTAL_CYCLES > RC_CYCLES) ? XTAL_CYCLES : RC_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] XTAL_LD = CW'(XTAL_CYCLES - 1);
  localparam logic [CW-1:0] RC_LD   = CW'(RC_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= osc_rc ? RC_LD : XTAL_LD;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sleep_exec,
  input  logic pending,
  input  logic gie,
  input  logic wdt_timeout,
  input  logic ext_reset_req,
  input  logic prefetch_retire,
  input  logic timer_done,
  output logic timer_load,
  output logic timer_run,
  output logic core_clk_en,
  output logic wdt_clear,
  output logic vector_req,
  output logic core_reset,
  output logic status_pd,
  output logic status_to
);
  slp_state_t state, state_n;
  wake_src_t  reason, reason_n;

  always_comb begin
    state_n  = state;
    reason_n = reason;
    unique case (state)
      ST_AWAKE: begin
        if (sleep_exec && !pending) state_n = ST_ASLEEP;
      end
      ST_ASLEEP: begin
        if (ext_reset_req) begin
          state_n  = ST_STARTUP;
          reason_n = WK_RST;
        end else if (wdt_timeout) begin
          state_n  = ST_STARTUP;
          reason_n = WK_WDT;
        end else if (pending) begin
          state_n  = ST_STARTUP;
          reason_n = WK_IRQ;
        end
      end
      ST_STARTUP: begin
        if (timer_done) state_n = (reason == WK_RST) ? ST_AWAKE : ST_RESUME;
      end
      ST_RESUME: begin
        if (prefetch_retire) state_n = ST_AWAKE;
      end
      default: state_n = ST_AWAKE;
    endcase
  end

  assign timer_load = (state == ST_ASLEEP) && (state_n == ST_STARTUP);
  assign timer_run  = (state == ST_STARTUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_AWAKE;
      reason      <= WK_IRQ;
      core_clk_en <= 1'b1;
      wdt_clear   <= 1'b0;
      vector_req  <= 1'b0;
      core_reset  <= 1'b0;
      status_pd   <= 1'b1;
      status_to   <= 1'b1;
    end else begin
      state       <= state_n;
      reason      <= reason_n;
      core_clk_en <= (state_n == ST_AWAKE) || (state_n == ST_RESUME);
      wdt_clear   <= timer_load;
      vector_req  <= (state == ST_RESUME) && prefetch_retire && gie;
      core_reset  <= (state == ST_STARTUP) && timer_done && (reason == WK_RST);
      if (state == ST_AWAKE && state_n == ST_ASLEEP) begin
        status_pd <= 1'b0;
        status_to <= 1'b1;
      end
      if (timer_load && reason_n == WK_WDT) status_to <= 1'b0;
      if (state == ST_STARTUP && timer_done && reason == WK_RST) status_to <= 1'b1;
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int N_IRQ       = 4,
  parameter int XTAL_CYCLES = 1024,
  parameter int RC_CYCLES   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_exec,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic             gie,
  input  logic             wdt_timeout,
  input  logic             ext_reset_req,
  input  logic             osc_rc,
  input  logic             prefetch_retire,
  output logic             core_clk_en,
  output logic             wdt_clear,
  output logic             vector_req,
  output logic             core_reset,
  output logic             status_pd,
  output logic             status_to
);
  logic pending;
  logic t_load, t_run, t_done;

  irq_pending #(.N_IRQ(N_IRQ)) u_pend (
    .irq_en   (irq_en),
    .irq_flag (irq_flag),
    .pending  (pending)
  );

  startup_timer #(.XTAL_CYCLES(XTAL_CYCLES), .RC_CYCLES(RC_CYCLES)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load   (t_load),
    .osc_rc (osc_rc),
    .run    (t_run),
    .done   (t_done)
  );

  sleep_fsm u_fsm (
    .clk             (clk),
    .rst             (rst),
    .sleep_exec      (sleep_exec),
    .pending         (pending),
    .gie             (gie),
    .wdt_timeout     (wdt_timeout),
    .ext_reset_req   (ext_reset_req),
    .prefetch_retire (prefetch_retire),
    .timer_done      (t_done),
    .timer_load      (t_load),
    .timer_run       (t_run),
    .core_clk_en     (core_clk_en),
    .wdt_clear       (wdt_clear),
    .vector_req      (vector_req),
    .core_reset      (core_reset),
    .status_pd       (status_pd),
    .status_to       (status_to)
  );
endmodule

// File: rtl/sleep_wake_chk.sv
module sleep_wake_chk #(
  parameter int N_IRQ = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_exec,
  input logic [N_IRQ-1:0] irq_en,
  input logic [N_IRQ-1:0] irq_flag,
  input logic             gie,
  input logic             prefetch_retire,
  input logic             core_clk_en,
  input logic             wdt_clear,
  input logic             vector_req,
  input logic             core_reset,
  input logic             status_pd,
  input logic             status_to
);
  p_pd_never_rises_r2: assert property (@(posedge clk) disable iff (rst)
    !$rose(status_pd));

  p_nop_keeps_state_r3: assert property (@(posedge clk) disable iff (rst)
    (core_clk_en && sleep_exec && |(irq_en & irq_flag)) |=> core_clk_en && $stable(status_pd));

  p_to_fall_on_wake_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(status_to) |-> wdt_clear);

  p_wdt_clear_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wdt_clear |=> !wdt_clear);

  p_clk_off_startup_r7: assert property (@(posedge clk) disable iff (rst)
    wdt_clear |-> !core_clk_en);

  p_vector_cause_r8: assert property (@(posedge clk) disable iff (rst)
    vector_req |-> $past(prefetch_retire) && $past(gie));

  p_vector_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    vector_req |=> !vector_req);

  p_reset_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    core_reset |-> !vector_req && $past(!core_clk_en));
endmodule

bind sleep_wake_ctrl sleep_wake_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .sleep_exec      (sleep_exec),
  .irq_en          (irq_en),
  .irq_flag        (irq_flag),
  .gie             (gie),
  .prefetch_retire (prefetch_retire),
  .core_clk_en     (core_clk_en),
  .wdt_clear       (wdt_clear),
  .vector_req      (vector_req),
  .core_reset      (core_reset),
  .status_pd       (status_pd),
  .status_to       (status_to)
);

// File: tb/sim_sleep_wake_ctrl.sv
module sim_sleep_wake_ctrl;
  localparam int N_IRQ = 4;
  localparam int XTAL  = 1024;
  localparam int RC    = 4;
  localparam int NV    = 7;
  // entry: {src[1:0], gie, osc_rc, exp_to, exp_core_reset, exp_vector}
  // src: 0 irq, 1 watchdog, 2 external reset, 3 all three together
  localparam logic [6:0] VEC [NV] = '{
    7'b00_0_1_1_0_0,
    7'b00_1_1_1_0_1,
    7'b01_0_1_0_0_0,
    7'b01_1_0_0_0_1,
    7'b10_1_1_1_1_0,
    7'b00_1_0_1_0_1,
    7'b11_1_1_1_1_0
  };

  logic clk = 1'b0, rst = 1'b1;
  logic sleep_exec = 1'b0, gie = 1'b0, wdt_timeout = 1'b0, ext_reset_req = 1'b0;
  logic osc_rc = 1'b1, prefetch_retire = 1'b0;
  logic [N_IRQ-1:0] irq_en = '0, irq_flag = '0;
  logic core_clk_en, wdt_clear, vector_req, core_reset, status_pd, status_to;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.N_IRQ(N_IRQ), .XTAL_CYCLES(XTAL), .RC_CYCLES(RC)) u0 (
    .clk(clk), .rst(rst), .sleep_exec(sleep_exec), .irq_en(irq_en), .irq_flag(irq_flag),
    .gie(gie), .wdt_timeout(wdt_timeout), .ext_reset_req(ext_reset_req), .osc_rc(osc_rc),
    .prefetch_retire(prefetch_retire), .core_clk_en(core_clk_en), .wdt_clear(wdt_clear),
    .vector_req(vector_req), .core_reset(core_reset), .status_pd(status_pd), .status_to(status_to)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [6:0] v);
    int n;
    @(negedge clk);
    gie = v[4]; osc_rc = v[3]; sleep_exec = 1'b1;
    @(negedge clk);
    sleep_exec = 1'b0;
    chk("R2 clk_en off", core_clk_en, 0);
    chk("R2 pd cleared", status_pd, 0);
    chk("R2 to set", status_to, 1);
    repeat (3) @(negedge clk);
    case (v[6:5])
      2'd0: begin irq_en = 4'b0100; irq_flag = 4'b0100; end
      2'd1: wdt_timeout = 1'b1;
      2'd2: ext_reset_req = 1'b1;
      default: begin wdt_timeout = 1'b1; ext_reset_req = 1'b1; irq_en = 4'b0001; irq_flag = 4'b0001; end
    endcase
    @(negedge clk);
    wdt_timeout = 1'b0; ext_reset_req = 1'b0; irq_en = '0; irq_flag = '0;
    chk("R6 wdt_clear on wake", wdt_clear, 1);
    chk("R5 timeout bit", status_to, v[2]);
    n = 0;
    while (!core_clk_en && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk("R7 startup length", n, v[3] ? RC : XTAL);
    if (v[1]) begin
      chk("R9 core_reset pulse", core_reset, 1);
      chk("R9 no vector", vector_req, 0);
      chk("R9 pd stays low", status_pd, 0);
      @(negedge clk);
      chk("R9 core_reset one cycle", core_reset, 0);
    end else begin
      chk("R8 no core_reset", core_reset, 0);
      prefetch_retire = 1'b1;
      @(negedge clk);
      prefetch_retire = 1'b0;
      chk("R8 vector by gie", vector_req, v[0]);
      @(negedge clk);
      chk("R8 vector one cycle", vector_req, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 clk_en", core_clk_en, 1);
    chk("R1 pd", status_pd, 1);
    chk("R1 to", status_to, 1);
    chk("R1 pulses", {wdt_clear, vector_req, core_reset}, 0);

    // R3: pending enabled interrupt with gie clear turns sleep into a no-op
    irq_en = 4'b0010; irq_flag = 4'b0010; gie = 1'b0; sleep_exec = 1'b1;
    @(negedge clk);
    sleep_exec = 1'b0; irq_en = '0; irq_flag = '0;
    chk("R3 clk stays on", core_clk_en, 1);
    chk("R3 pd kept", status_pd, 1);
    chk("R3 to kept", status_to, 1);

    // R10: watchdog and external reset while awake do nothing
    wdt_timeout = 1'b1; ext_reset_req = 1'b1;
    @(negedge clk);
    wdt_timeout = 1'b0; ext_reset_req = 1'b0;
    chk("R10 no core_reset awake", core_reset, 0);
    chk("R10 to kept awake", status_to, 1);
    chk("R10 clk on awake", core_clk_en, 1);
    chk("R10 no wdt_clear awake", wdt_clear, 0);

    for (int i = 0; i < NV; i++) run_case(VEC[i]);

    // R4: flag without enable, gie, and a sleep strobe while asleep do not wake
    @(negedge clk);
    osc_rc = 1'b1; gie = 1'b0; sleep_exec = 1'b1;
    @(negedge clk);
    sleep_exec = 1'b0;
    irq_en = 4'b0100; irq_flag = 4'b0010; gie = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 no wake without enable", core_clk_en, 0);
    chk("R4 no wdt_clear", wdt_clear, 0);
    sleep_exec = 1'b1;
    @(negedge clk);
    sleep_exec = 1'b0;
    chk("R10 sleep while asleep ignored", {core_clk_en, wdt_clear}, 0);
    irq_en = 4'b0110;
    @(negedge clk);
    irq_en = '0; irq_flag = '0;
    chk("R4 enabled flag wakes", wdt_clear, 1);
    chk("R5 irq wake keeps to", status_to, 1);
    repeat (RC) @(negedge clk);
    chk("R8 clock back", core_clk_en, 1);
    prefetch_retire = 1'b1;
    @(negedge clk);
    prefetch_retire = 1'b0;
    chk("R8 vector with gie set", vector_req, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule